// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block lights an N-digit seven-segment LED display one digit at a time from a held BCD result. Each digit gets a lit slot of a fixed number of timebase ticks. A short dark gap follows every slot, with all drivers off, so that one digit's pattern does not ghost onto the next. The scan runs from the least significant digit (digit 1) up to the most significant digit and then wraps. The slot and gap lengths are counted in ticks of a clock-enable input. With a 1 µs tick and the default parameters, eight digits are scanned at 500 Hz.

The decimal point position depends on the measurement function, the range and the timebase selection. An external digit index can override it. Zeros to the left of the decimal point are suppressed until the first nonzero digit. Digits to the right of the point are always shown. An overflowed result keeps every zero and lights the decimal point of the most significant digit. A display test lights every segment, and display off darkens everything. One parameter sets the polarity of every output for common-anode or common-cathode displays.

Top module: `ledScanner`

## Requirements
- R1: While `rstN` is low every digit and segment driver is inactive, and after release the scan starts in a dark gap and then lights digit 1 first.
- R2: Each digit is lit for SLOT_TICKS ticks with exactly one strobe active, followed by GAP_TICKS ticks with all drivers inactive. Digits go in ascending order and wrap after the last. The scan position moves only in cycles where `tick` is high.
- R3: `segOut` bits 0 to 6 are segments a to g and bit 7 is the decimal point. BCD values 0 to 9 light the usual patterns: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F. Values 10 to 15 light no segment. Digit k (1-based) is `bcdWord[4k-1:4k-4]`.
- R4: The function codes are 0 frequency, 1 period, 2 ratio, 3 interval, 4 totalize and 5 self-frequency; codes 6 and 7 behave as frequency. For range r (0..3) the decimal point sits on digit r+2 in frequency, period, interval and self-frequency, on digit r+1 in ratio, and always on digit 1 in totalize.
- R5: With `oneMhz` high, the decimal point moves one digit further toward the most significant end in period and interval functions only.
- R6: With `extDpEn` high, the decimal point sits on the 0-based digit index `extDpDigit` instead of the mode position, and zero suppression stops at that digit.
- R7: A zero digit above the decimal point is blank when it and every more significant digit are zero. The digit holding the decimal point and all digits below it are always shown.
- R8: When `overflow` is high no digit is suppressed, and the decimal point of the most significant digit is lit.
- R9: With `dispTest` high and `dispOff` low, every lit digit shows all seven segments and its decimal point.
- R10: With `dispOff` high every digit and segment driver is inactive, whatever `dispTest` says.
- R11: With COMMON_CATHODE=1 every output bit is active low; with COMMON_CATHODE=0 every output bit is active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase clock enable, one tick per scan time unit |
| bcdWord | input | 4*NUM_DIGITS | Held BCD result, digit 1 in the low nibble |
| overflow | input | 1 | Result overflowed |
| funcSel | input | 3 | Measurement function code |
| rangeSel | input | 2 | Range code 0..3 |
| oneMhz | input | 1 | Slow timebase selected |
| extDpEn | input | 1 | Use the external decimal point digit |
| extDpDigit | input | $clog2(NUM_DIGITS) | External decimal point digit, 0-based |
| dispTest | input | 1 | Light all segments |
| dispOff | input | 1 | Turn every driver off |
| digitOut | output | NUM_DIGITS | Digit strobes, bit 0 is digit 1 |
| segOut | output | 8 | Segments a..g in bits 0..6, decimal point in bit 7 |

## Verification
The bench builds the block with eight digits, a three-tick slot and a one-tick gap, and drives `tick` every cycle except in one stretch. A full scan of all eight digits then takes 32 cycles. That short scan makes it practical to compare every output bit in every cycle against a bench model, across every function code, range, timebase setting and external decimal point index, and across several zero patterns with and without overflow. A second copy built with COMMON_CATHODE=1 runs on the same inputs, and its outputs are compared against the inverted expectation.

// File: rtl/ledScanPkg.sv
package ledScanPkg;

  typedef enum logic [2:0] {
    FN_FREQ     = 3'd0,
    FN_PERIOD   = 3'd1,
    FN_RATIO    = 3'd2,
    FN_INTERVAL = 3'd3,
    FN_TOTAL    = 3'd4,
    FN_SELF     = 3'd5
  } fnCode_e;

  // Strobes from the scan timer to the display datapath
  typedef struct packed {
    logic lit;   // digit slot is in its lit part
    logic step;  // move to the next digit now
  } scanStrobe_t;

  // Segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] sevenSeg(input logic [3:0] v);
    case (v)
      4'd0: sevenSeg = 7'h3F;
      4'd1: sevenSeg = 7'h06;
      4'd2: sevenSeg = 7'h5B;
      4'd3: sevenSeg = 7'h4F;
      4'd4: sevenSeg = 7'h66;
      4'd5: sevenSeg = 7'h6D;
      4'd6: sevenSeg = 7'h7D;
      4'd7: sevenSeg = 7'h07;
      4'd8: sevenSeg = 7'h7F;
      4'd9: sevenSeg = 7'h6F;
      default: sevenSeg = 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/ledScanTimer.sv
module ledScanTimer
  import ledScanPkg::*;
#(
  parameter int SLOT_TICKS = 244,
  parameter int GAP_TICKS  = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  output scanStrobe_t strb
);

  localparam int FRAME = SLOT_TICKS + GAP_TICKS;
  localparam int CW    = (FRAME > 1) ? $clog2(FRAME) : 1;

  logic [CW-1:0] slotCnt;
  logic          frameEnd;

  assign frameEnd = (slotCnt == CW'(FRAME - 1));

  // Reset parks the timer at the start of a gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= CW'(SLOT_TICKS);
    end else if (tick) begin
      slotCnt <= frameEnd ? '0 : slotCnt + CW'(1);
    end
  end

  assign strb.lit  = (slotCnt < CW'(SLOT_TICKS));
  assign strb.step = tick && frameEnd;

endmodule

// File: rtl/ledScanData.sv
module ledScanData
  import ledScanPkg::*;
#(
  parameter int NUM_DIGITS     = 8,
  parameter bit COMMON_CATHODE = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  scanStrobe_t                   strb,
  input  logic [4*NUM_DIGITS-1:0]       bcdWord,
  input  logic                          overflow,
  input  logic [2:0]                    funcSel,
  input  logic [1:0]                    rangeSel,
  input  logic                          oneMhz,
  input  logic                          extDpEn,
  input  logic [$clog2(NUM_DIGITS)-1:0] extDpDigit,
  input  logic                          dispTest,
  input  logic                          dispOff,
  output logic [NUM_DIGITS-1:0]         digitOut,
  output logic [7:0]                    segOut
);

  localparam int IW   = $clog2(NUM_DIGITS);
  localparam int PW   = IW + 1;
  localparam logic [IW-1:0] LAST = IW'(NUM_DIGITS - 1);

  logic [IW-1:0]         digitIdx;
  logic [3:0]            digitVal [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] blankMask;
  logic [PW-1:0]         modeDp;
  logic [PW-1:0]         dpPos;
  logic                  zeroRun;
  logic [NUM_DIGITS-1:0] strobeL;
  logic [7:0]            segL;
  logic [3:0]            curVal;

  // Digit pointer, parked on the last digit so that digit 1 comes first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digitIdx <= LAST;
    end else if (strb.step) begin
      digitIdx <= (digitIdx == LAST) ? '0 : digitIdx + IW'(1);
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gSplit
    assign digitVal[g] = bcdWord[4*g +: 4];
  end

  // Decimal point position, 0-based digit index
  always_comb begin
    case (funcSel)
      FN_RATIO: modeDp = PW'(rangeSel);
      FN_TOTAL: modeDp = '0;
      default:  modeDp = PW'(rangeSel) + PW'(1);
    endcase
    if (oneMhz && (funcSel == FN_PERIOD || funcSel == FN_INTERVAL)) begin
      modeDp = modeDp + PW'(1);
    end
    dpPos = extDpEn ? {1'b0, extDpDigit} : modeDp;
  end

  // Leading zero run from the most significant digit downwards
  always_comb begin
    zeroRun = 1'b1;
    for (int i = NUM_DIGITS - 1; i >= 0; i--) begin
      zeroRun      = zeroRun && (digitVal[i] == 4'd0);
      blankMask[i] = zeroRun && !overflow && (PW'(i) > dpPos);
    end
  end

  assign curVal = digitVal[digitIdx];

  always_comb begin
    strobeL = '0;
    segL    = '0;
    if (!dispOff && strb.lit) begin
      strobeL[digitIdx] = 1'b1;
      if (dispTest) begin
        segL = 8'hFF;
      end else begin
        segL[6:0] = blankMask[digitIdx] ? 7'h00 : sevenSeg(curVal);
        segL[7]   = ({1'b0, digitIdx} == dpPos) || (overflow && digitIdx == LAST);
      end
    end
  end

  if (COMMON_CATHODE) begin : gActLow
    assign digitOut = ~strobeL;
    assign segOut   = ~segL;
  end else begin : gActHigh
    assign digitOut = strobeL;
    assign segOut   = segL;
  end

endmodule

// File: rtl/ledScanner.sv
module ledScanner
  import ledScanPkg::*;
#(
  parameter int NUM_DIGITS     = 8,
  parameter int SLOT_TICKS     = 244,
  parameter int GAP_TICKS      = 6,
  parameter bit COMMON_CATHODE = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  logic [4*NUM_DIGITS-1:0]       bcdWord,
  input  logic                          overflow,
  input  logic [2:0]                    funcSel,
  input  logic [1:0]                    rangeSel,
  input  logic                          oneMhz,
  input  logic                          extDpEn,
  input  logic [$clog2(NUM_DIGITS)-1:0] extDpDigit,
  input  logic                          dispTest,
  input  logic                          dispOff,
  output logic [NUM_DIGITS-1:0]         digitOut,
  output logic [7:0]                    segOut
);

  scanStrobe_t strb;

  ledScanTimer #(
    .SLOT_TICKS(SLOT_TICKS),
    .GAP_TICKS (GAP_TICKS)
  ) u_timer (
    .clk (clk),
    .rstN(rstN),
    .tick(tick),
    .strb(strb)
  );

  ledScanData #(
    .NUM_DIGITS    (NUM_DIGITS),
    .COMMON_CATHODE(COMMON_CATHODE)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bcdWord   (bcdWord),
    .overflow  (overflow),
    .funcSel   (funcSel),
    .rangeSel  (rangeSel),
    .oneMhz    (oneMhz),
    .extDpEn   (extDpEn),
    .extDpDigit(extDpDigit),
    .dispTest  (dispTest),
    .dispOff   (dispOff),
    .digitOut  (digitOut),
    .segOut    (segOut)
  );

endmodule

// File: rtl/ledScannerChk.sv
module ledScannerChk #(
  parameter int NUM_DIGITS     = 8,
  parameter bit COMMON_CATHODE = 1'b0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  overflow,
  input logic                  dispTest,
  input logic                  dispOff,
  input logic [NUM_DIGITS-1:0] digitOut,
  input logic [7:0]            segOut
);

  logic [NUM_DIGITS-1:0] strobeL;
  logic [7:0]            segL;

  assign strobeL = COMMON_CATHODE ? ~digitOut : digitOut;
  assign segL    = COMMON_CATHODE ? ~segOut   : segOut;

  // R2: one strobe at most, never a direct switch between two digits
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeL));

  a_r2_gap_between: assert property (@(posedge clk) disable iff (!rstN)
    (strobeL != '0 && $past(strobeL) != '0) |-> strobeL == $past(strobeL));

  a_r2_dark_segments: assert property (@(posedge clk) disable iff (!rstN)
    (strobeL == '0) |-> (segL == 8'h00));

  a_r8_ovf_msd: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !dispOff && strobeL[NUM_DIGITS-1]) |-> segL[7]);

  a_r9_test_all: assert property (@(posedge clk) disable iff (!rstN)
    (dispTest && !dispOff && strobeL != '0) |-> (segL == 8'hFF));

  a_r10_off_dark: assert property (@(posedge clk) disable iff (!rstN)
    dispOff |-> (strobeL == '0 && segL == 8'h00));

endmodule

bind ledScanner ledScannerChk #(
  .NUM_DIGITS    (NUM_DIGITS),
  .COMMON_CATHODE(COMMON_CATHODE)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .overflow(overflow),
  .dispTest(dispTest),
  .dispOff (dispOff),
  .digitOut(digitOut),
  .segOut  (segOut)
);

// File: tb/test_ledScanner.sv
`timescale 1ns/100ps
module test_ledScanner;

  localparam int ND    = 8;
  localparam int SLOT  = 3;
  localparam int GAP   = 1;
  localparam int FRAME = SLOT + GAP;
  localparam int SCAN  = ND * FRAME;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b1;
  logic [4*ND-1:0] bcdWord = '0;
  logic          overflow = 1'b0;
  logic [2:0]    funcSel = 3'd0;
  logic [1:0]    rangeSel = 2'd0;
  logic          oneMhz = 1'b0;
  logic          extDpEn = 1'b0;
  logic [2:0]    extDpDigit = 3'd0;
  logic          dispTest = 1'b0;
  logic          dispOff = 1'b0;
  logic [ND-1:0] digitOut, digitCc;
  logic [7:0]    segOut, segCc;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string curTag = "R1";
  int    mCnt, mIdx;

  always #2.5 clk = ~clk;

  ledScanner #(.NUM_DIGITS(ND), .SLOT_TICKS(SLOT), .GAP_TICKS(GAP), .COMMON_CATHODE(1'b0))
  i_ledScanner (
    .clk(clk), .rstN(rstN), .tick(tick), .bcdWord(bcdWord), .overflow(overflow),
    .funcSel(funcSel), .rangeSel(rangeSel), .oneMhz(oneMhz), .extDpEn(extDpEn),
    .extDpDigit(extDpDigit), .dispTest(dispTest), .dispOff(dispOff),
    .digitOut(digitOut), .segOut(segOut));

  ledScanner #(.NUM_DIGITS(ND), .SLOT_TICKS(SLOT), .GAP_TICKS(GAP), .COMMON_CATHODE(1'b1))
  i_ledScanner_cc (
    .clk(clk), .rstN(rstN), .tick(tick), .bcdWord(bcdWord), .overflow(overflow),
    .funcSel(funcSel), .rangeSel(rangeSel), .oneMhz(oneMhz), .extDpEn(extDpEn),
    .extDpDigit(extDpDigit), .dispTest(dispTest), .dispOff(dispOff),
    .digitOut(digitCc), .segOut(segCc));

  // Scan position model (R1, R2)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= SLOT;
      mIdx <= ND - 1;
    end else if (tick) begin
      if (mCnt == FRAME - 1) begin
        mCnt <= 0;
        mIdx <= (mIdx == ND - 1) ? 0 : mIdx + 1;
      end else begin
        mCnt <= mCnt + 1;
      end
    end
  end

  function automatic logic [6:0] refSeg(input logic [3:0] v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [15:0] expOut();
    logic [7:0] dg, sg;
    int dp, run;
    dg = '0; sg = '0;
    if (!dispOff && mCnt < SLOT) begin
      dg[mIdx] = 1'b1;
      if (dispTest) sg = 8'hFF;
      else begin
        case (funcSel)
          2: dp = rangeSel;
          4: dp = 0;
          default: dp = rangeSel + 1;
        endcase
        if (oneMhz && (funcSel == 1 || funcSel == 3)) dp = dp + 1;
        if (extDpEn) dp = extDpDigit;
        run = 1;
        for (int i = ND - 1; i >= mIdx; i--)
          if (bcdWord[4*i +: 4] != 0) run = 0;
        if (run == 1 && mIdx > dp && !overflow) sg[6:0] = 7'h00;
        else sg[6:0] = refSeg(bcdWord[4*mIdx +: 4]);
        sg[7] = (mIdx == dp) || (overflow && mIdx == ND - 1);
      end
    end
    return {dg, sg};
  endfunction

  always @(posedge clk) begin
    logic [15:0] e;
    #2;
    if (!done) begin
      e = expOut();
      checks++;
      if ({digitOut, segOut} !== e) begin
        errors++;
        $display("FAIL %s: digit/seg actual %h/%h expected %h/%h (idx %0d cnt %0d)",
                 curTag, digitOut, segOut, e[15:8], e[7:0], mIdx, mCnt);
      end
      checks++;
      if ({digitCc, segCc} !== ~e) begin
        errors++;
        $display("FAIL R11: inverted digit/seg actual %h/%h expected %h/%h",
                 digitCc, segCc, ~e[15:8], ~e[7:0]);
      end
    end
  end

  task automatic runScans(input int n);
    repeat (n * SCAN) @(negedge clk);
  endtask

  task automatic setCfg(input logic [2:0] fn, input logic [1:0] rg, input logic mhz,
                        input logic [31:0] w, input logic ov);
    @(negedge clk);
    funcSel = fn; rangeSel = rg; oneMhz = mhz; bcdWord = w; overflow = ov;
  endtask

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'h00000000; pats[1] = 32'h00000001; pats[2] = 32'h00120000;
    pats[3] = 32'h10000000; pats[4] = 32'h00000500;

    // R1: reset state and first digit after release
    curTag = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    runScans(1);

    // R3: decoding of every nibble value
    curTag = "R3";
    setCfg(3'd4, 2'd0, 1'b0, 32'h76543210, 1'b0); runScans(2);
    setCfg(3'd4, 2'd0, 1'b0, 32'h98FEDCBA, 1'b0); runScans(2);

    // R4 and R5: decimal point over every function, range, timebase
    for (int mhz = 0; mhz < 2; mhz++) begin
      curTag = (mhz == 0) ? "R4" : "R5";
      for (int fn = 0; fn < 8; fn++)
        for (int rg = 0; rg < 4; rg++) begin
          setCfg(3'(fn), 2'(rg), 1'(mhz), 32'h00000000, 1'b0); runScans(1);
          setCfg(3'(fn), 2'(rg), 1'(mhz), 32'h00100000, 1'b0); runScans(1);
        end
    end

    // R7: zero suppression patterns; R8: same with overflow
    for (int ov = 0; ov < 2; ov++) begin
      curTag = (ov == 0) ? "R7" : "R8";
      for (int p = 0; p < 5; p++)
        for (int rg = 0; rg < 4; rg++) begin
          setCfg(3'd0, 2'(rg), 1'b0, pats[p], 1'(ov)); runScans(1);
        end
    end

    // R6: external decimal point digit
    curTag = "R6";
    @(negedge clk) extDpEn = 1'b1;
    for (int d = 0; d < ND; d++) begin
      @(negedge clk) extDpDigit = 3'(d);
      setCfg(3'd2, 2'd3, 1'b0, 32'h00000000, 1'b0); runScans(1);
      setCfg(3'd1, 2'd0, 1'b1, 32'h00030000, 1'b0); runScans(1);
    end
    @(negedge clk) extDpEn = 1'b0;

    // R9: display test, with and without overflow
    curTag = "R9";
    setCfg(3'd0, 2'd1, 1'b0, 32'h00000000, 1'b0);
    @(negedge clk) dispTest = 1'b1; runScans(1);
    setCfg(3'd0, 2'd1, 1'b0, 32'h00000000, 1'b1); runScans(1);

    // R10: display off beats display test
    curTag = "R10";
    @(negedge clk) dispOff = 1'b1; runScans(1);
    @(negedge clk) dispTest = 1'b0; runScans(1);
    @(negedge clk) dispOff = 1'b0;

    // R2: scan advances only on ticks
    curTag = "R2";
    setCfg(3'd4, 2'd0, 1'b0, 32'h87654321, 1'b0);
    @(negedge clk) tick = 1'b0;
    repeat (20) @(negedge clk);
    for (int k = 0; k < 3 * SCAN; k++) begin
      @(negedge clk) tick = ((k % 3) != 1);
    end
    @(negedge clk) tick = 1'b1;
    runScans(1);

    // R1: reset in the middle of a scan
    curTag = "R1";
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    runScans(1);

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule